// File: doc/BRIEF.md
# Output-Compare Channel with Pulse Pin

This block is a single output-compare channel that watches a free-running 31-bit nanosecond counter supplied from outside. Software arms it with a target value; when the counter equals the active target, the channel latches a sticky match flag, can raise an interrupt, and drives a pin in one of two waveforms. In toggle mode the pin inverts on each match. In pulse mode the pin is high for one clock. A pulse-per-second output is built by placing targets one second apart.

The target is held in two slots, so software can stay one period ahead. The first target written while the channel is unarmed goes straight into the active slot. Any later write goes into a waiting slot, and that value replaces the active target only when the current one matches. A small state machine tracks the slots. Its states are `SLOT_IDLE` (nothing armed), `SLOT_LIVE` (active target only) and `SLOT_QUEUED` (active plus waiting target). Its transitions are:
- arm: `SLOT_IDLE` to `SLOT_LIVE` on a target write.
- queue: `SLOT_LIVE` to `SLOT_QUEUED` on a target write.
- promote: `SLOT_QUEUED` to `SLOT_LIVE` on a match with no write in the same cycle.
- requeue: stay in `SLOT_QUEUED` on a match together with a write.
- disarm: any state to `SLOT_IDLE` on a control write whose mode field is zero.

Top module: `cmp_pulse_chan`

## Requirements
- R1: After reset, `ctrl_o` reads 0x00, `tgt_o` reads 0, and `pin_o` and `irq_o` are low.
- R2: A control write (`wr_sel_i`=0) stores `wr_data_i[0]` as the DMA-request enable bit, `wr_data_i[5:2]` as the mode and `wr_data_i[6]` as the interrupt enable. `ctrl_o` returns {flag[7], irq enable[6], mode[5:2], 0[1], DMA enable[0]}. The DMA bit has no other effect.
- R3: A target write (`wr_sel_i`=1) made while unarmed loads the active target, which is visible on `tgt_o` the next cycle. Only `wr_data_i[30:0]` is kept; bit 31 is discarded.
- R4: A target write made while armed is held as the waiting target. `tgt_o` keeps its value until a match, and the waiting value appears on `tgt_o` the cycle after that match.
- R5: If a match occurs with no waiting target, `tgt_o` keeps the old value, so the same target matches again when the counter returns to it.
- R6: When armed, with a nonzero mode and `count_i` equal to the active target, flag bit 7 of `ctrl_o` is set the next cycle. With mode 0, equality sets nothing.
- R7: The flag is cleared only by a control write with bit 7 set. A control write with bit 7 clear leaves the flag set, and a match in the same cycle as a clearing write keeps the flag set.
- R8: `irq_o` is high exactly when both the flag and the interrupt enable are set.
- R9: With mode 0x5, `pin_o` inverts in the cycle after each match and holds otherwise.
- R10: With mode 0xF, `pin_o` is high for the single cycle after a match and low otherwise.
- R11: A control write with mode 0 disarms the channel and discards any waiting target. `pin_o` is low while the mode is 0, and the next target write acts as a first write (R3).
- R12: With any mode other than 0, 0x5 and 0xF, a match sets the flag but `pin_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_i | input | 31 | Current value of the timestamp counter |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects control/status, 1 selects target |
| wr_data_i | input | 32 | Write data |
| ctrl_o | output | 8 | Control/status readback |
| tgt_o | output | 31 | Active compare target |
| pin_o | output | 1 | Compare output pin |
| irq_o | output | 1 | Interrupt request |

## Verification
A slot state machine in the wrong state shows up on `tgt_o` within one cycle of the next match. The active target either fails to advance to the queued value, or advances when no value was queued. A first write that lands in the waiting slot instead leaves `tgt_o` stale one cycle after the write. A wrong flag or mode register shows on `ctrl_o`, `irq_o` and `pin_o` in the cycle after the write or match that disturbed it. The pulse width and the toggle parity are therefore checked one cycle and two cycles after each match.

// File: rtl/cmpch_pkg.sv
package cmpch_pkg;
    typedef enum logic [1:0] {
        SLOT_IDLE   = 2'd0,
        SLOT_LIVE   = 2'd1,
        SLOT_QUEUED = 2'd2
    } slot_state_t;

    localparam int MODE_W = 4;
    localparam logic [MODE_W-1:0] MODE_OFF    = 4'h0;
    localparam logic [MODE_W-1:0] MODE_TOGGLE = 4'h5;
    localparam logic [MODE_W-1:0] MODE_PULSE  = 4'hF;

    localparam int BIT_DMA  = 0;
    localparam int MODE_LSB = 2;
    localparam int BIT_IE   = 6;
    localparam int BIT_FLAG = 7;
    localparam int CTRL_W   = 8;

    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_TGT  = 1'b1;
endpackage

// File: rtl/cmpch_regs.sv
module cmpch_regs
    import cmpch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [CTRL_W-1:0] wr_val,
    input  logic              hit,
    output logic [MODE_W-1:0] mode,
    output logic              ie,
    output logic              flag,
    output logic [CTRL_W-1:0] ctrl_q
);
    logic dma_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dma_en <= 1'b0;
            mode   <= MODE_OFF;
            ie     <= 1'b0;
        end else if (wr_ctrl) begin
            dma_en <= wr_val[BIT_DMA];
            mode   <= wr_val[MODE_LSB +: MODE_W];
            ie     <= wr_val[BIT_IE];
        end
    end

    // sticky flag: a match outranks a clearing write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (wr_ctrl && wr_val[BIT_FLAG]) begin
            flag <= 1'b0;
        end
    end

    always_comb begin
        ctrl_q                        = '0;
        ctrl_q[BIT_DMA]               = dma_en;
        ctrl_q[MODE_LSB +: MODE_W]    = mode;
        ctrl_q[BIT_IE]                = ie;
        ctrl_q[BIT_FLAG]              = flag;
    end
endmodule

// File: rtl/cmpch_target.sv
module cmpch_target
    import cmpch_pkg::*;
#(
    parameter int CW = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_tgt,
    input  logic [CW-1:0] wr_val,
    input  logic          disarm,
    input  logic          hit_en,
    input  logic [CW-1:0] count,
    output logic          hit,
    output logic [CW-1:0] active,
    output slot_state_t   state
);
    slot_state_t   state_nxt;
    logic [CW-1:0] waiting;
    logic          load_active;
    logic          load_wait;
    logic          promote;

    assign hit = (state != SLOT_IDLE) && hit_en && (count == active);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SLOT_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt   = state;
        load_active = 1'b0;
        load_wait   = 1'b0;
        promote     = 1'b0;
        if (disarm) begin
            state_nxt = SLOT_IDLE;
        end else begin
            unique case (state)
                SLOT_IDLE: begin
                    if (wr_tgt) begin
                        load_active = 1'b1;
                        state_nxt   = SLOT_LIVE;
                    end
                end
                SLOT_LIVE: begin
                    if (wr_tgt) begin
                        load_wait = 1'b1;
                        state_nxt = SLOT_QUEUED;
                    end
                end
                SLOT_QUEUED: begin
                    if (hit) begin
                        promote   = 1'b1;
                        state_nxt = wr_tgt ? SLOT_QUEUED : SLOT_LIVE;
                    end
                    if (wr_tgt) load_wait = 1'b1;
                end
                default: state_nxt = SLOT_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active  <= '0;
            waiting <= '0;
        end else begin
            if (load_active)  active <= wr_val;
            else if (promote) active <= waiting;
            if (load_wait)    waiting <= wr_val;
        end
    end
endmodule

// File: rtl/cmpch_pin.sv
module cmpch_pin
    import cmpch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              hit,
    output logic              pin
);
    logic pin_nxt;

    always_comb begin
        unique case (mode)
            MODE_TOGGLE: pin_nxt = hit ? ~pin : pin;
            MODE_PULSE:  pin_nxt = hit;
            default:     pin_nxt = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin <= 1'b0;
        else        pin <= pin_nxt;
    end
endmodule

// File: rtl/cmp_pulse_chan.sv
module cmp_pulse_chan
    import cmpch_pkg::*;
#(
    parameter int CW = 31,
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     count_i,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [DW-1:0]     wr_data_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [CW-1:0]     tgt_o,
    output logic              pin_o,
    output logic              irq_o
);
    logic              wr_ctrl;
    logic              wr_tgt;
    logic              disarm;
    logic              hit;
    logic              ie;
    logic              flag;
    logic [MODE_W-1:0] mode;
    slot_state_t       slot_state;

    assign wr_ctrl = wr_en_i && (wr_sel_i == SEL_CTRL);
    assign wr_tgt  = wr_en_i && (wr_sel_i == SEL_TGT);
    assign disarm  = wr_ctrl && (wr_data_i[MODE_LSB +: MODE_W] == MODE_OFF);

    cmpch_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ctrl(wr_ctrl),
        .wr_val (wr_data_i[CTRL_W-1:0]),
        .hit    (hit),
        .mode   (mode),
        .ie     (ie),
        .flag   (flag),
        .ctrl_q (ctrl_o)
    );

    cmpch_target #(.CW(CW)) u_tgt (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_tgt (wr_tgt),
        .wr_val (wr_data_i[CW-1:0]),
        .disarm (disarm),
        .hit_en (mode != MODE_OFF),
        .count  (count_i),
        .hit    (hit),
        .active (tgt_o),
        .state  (slot_state)
    );

    cmpch_pin u_pin (
        .clk  (clk),
        .rst_n(rst_n),
        .mode (mode),
        .hit  (hit),
        .pin  (pin_o)
    );

    assign irq_o = flag & ie;
endmodule

// File: rtl/cmpch_checker.sv
module cmpch_checker
    import cmpch_pkg::*;
#(
    parameter int CW = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_ctrl,
    input logic              wr_tgt,
    input logic              disarm,
    input logic [31:0]       wr_data_i,
    input logic              hit,
    input slot_state_t       slot_state,
    input logic [CTRL_W-1:0] ctrl_o,
    input logic [CW-1:0]     tgt_o,
    input logic              pin_o
);
    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[BIT_FLAG] && !(wr_ctrl && wr_data_i[BIT_FLAG]) |=> ctrl_o[BIT_FLAG]);

    // R6
    hit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> ctrl_o[BIT_FLAG]);

    // R10
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_o && ctrl_o[MODE_LSB +: MODE_W] == MODE_PULSE && !hit |=> !pin_o);

    // R9
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit && ctrl_o[MODE_LSB +: MODE_W] == MODE_TOGGLE |=> pin_o != $past(pin_o));

    // R11
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[MODE_LSB +: MODE_W] == MODE_OFF |=> !pin_o);

    // R5
    target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_state == SLOT_LIVE && !disarm |=> $stable(tgt_o));

    // R4
    queue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_state == SLOT_QUEUED && !hit && !wr_tgt |=> slot_state == SLOT_QUEUED || $past(disarm));
endmodule

bind cmp_pulse_chan cmpch_checker #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (wr_ctrl),
    .wr_tgt    (wr_tgt),
    .disarm    (disarm),
    .wr_data_i (wr_data_i),
    .hit       (hit),
    .slot_state(slot_state),
    .ctrl_o    (ctrl_o),
    .tgt_o     (tgt_o),
    .pin_o     (pin_o)
);

// File: tb/sim_cmp_pulse_chan.sv
module sim_cmp_pulse_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [30:0] count_i = '0;
    logic        wr_en_i = 1'b0;
    logic        wr_sel_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic [7:0]  ctrl_o;
    logic [30:0] tgt_o;
    logic        pin_o;
    logic        irq_o;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    cmp_pulse_chan u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_i  (count_i),
        .wr_en_i  (wr_en_i),
        .wr_sel_i (wr_sel_i),
        .wr_data_i(wr_data_i),
        .ctrl_o   (ctrl_o),
        .tgt_o    (tgt_o),
        .pin_o    (pin_o),
        .irq_o    (irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0; wr_data_i = '0;
    endtask

    // present value for one edge, then move counter away
    task automatic hit_at(input logic [30:0] v);
        @(negedge clk);
        count_i = v;
        @(negedge clk);
        count_i = v + 31'd7;
    endtask

    task automatic t_reset;
        chk("R1 ctrl", {24'd0, ctrl_o}, 32'h00);
        chk("R1 tgt", {1'b0, tgt_o}, 32'd0);
        chk("R1 pin", {31'd0, pin_o}, 32'd0);
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic t_fields;
        wr(1'b0, 32'h0000_0047);
        chk("R2 layout", {24'd0, ctrl_o}, 32'h45);
        chk("R8 no flag", {31'd0, irq_o}, 32'd0);
        wr(1'b0, 32'h0);
        chk("R11 cleared", {24'd0, ctrl_o}, 32'h00);
    endtask

    task automatic t_queue_toggle;
        wr(1'b1, 32'h8000_0064);
        chk("R3 first load masked", {1'b0, tgt_o}, 32'd100);
        wr(1'b1, 32'd200);
        chk("R4 queued not active", {1'b0, tgt_o}, 32'd100);
        wr(1'b0, 32'h54);
        hit_at(31'd100);
        chk("R6 flag set", {24'd0, ctrl_o}, 32'hD4);
        chk("R8 irq", {31'd0, irq_o}, 32'd1);
        chk("R9 toggle up", {31'd0, pin_o}, 32'd1);
        chk("R4 promoted", {1'b0, tgt_o}, 32'd200);
        wr(1'b0, 32'h54);
        chk("R7 bit7 zero keeps", {24'd0, ctrl_o}, 32'hD4);
        wr(1'b0, 32'hD4);
        chk("R7 w1c", {24'd0, ctrl_o}, 32'h54);
        chk("R8 irq low", {31'd0, irq_o}, 32'd0);
        hit_at(31'd200);
        chk("R9 toggle down", {31'd0, pin_o}, 32'd0);
        chk("R5 holds", {1'b0, tgt_o}, 32'd200);
        hit_at(31'd200);
        chk("R5 rematch", {31'd0, pin_o}, 32'd1);
        chk("R5 still", {1'b0, tgt_o}, 32'd200);
    endtask

    task automatic t_pulse;
        wr(1'b1, 32'd999);
        wr(1'b0, 32'h0);
        wr(1'b1, 32'd300);
        chk("R11 pin low off", {31'd0, pin_o}, 32'd0);
        chk("R11 rearm first", {1'b0, tgt_o}, 32'd300);
        wr(1'b0, 32'hBC);
        chk("R7 cleared", {24'd0, ctrl_o}, 32'h3C);
        hit_at(31'd300);
        chk("R10 pulse high", {31'd0, pin_o}, 32'd1);
        chk("R8 ie off", {31'd0, irq_o}, 32'd0);
        chk("R11 no stale queue", {1'b0, tgt_o}, 32'd300);
        @(negedge clk);
        chk("R10 one cycle", {31'd0, pin_o}, 32'd0);
    endtask

    task automatic t_other_modes;
        wr(1'b0, 32'h80);
        wr(1'b1, 32'd50);
        hit_at(31'd50);
        chk("R6 mode0 ignored", {24'd0, ctrl_o}, 32'h00);
        wr(1'b0, 32'h08);
        hit_at(31'd50);
        chk("R12 flag", {24'd0, ctrl_o}, 32'h88);
        chk("R12 pin low", {31'd0, pin_o}, 32'd0);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = 1'b0; wr_data_i = 32'h88; count_i = 31'd50;
        @(negedge clk);
        wr_en_i = 1'b0; wr_data_i = '0; count_i = 31'd51;
        chk("R7 match beats clear", {24'd0, ctrl_o}, 32'h88);
        wr(1'b0, 32'h88);
        chk("R7 later clear", {24'd0, ctrl_o}, 32'h08);
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_queue_toggle();
        t_pulse();
        t_other_modes();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule